// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block carries words between two unrelated clock domains. A writer pushes words on `wclk` and a reader takes them on `rclk`. Each pointer crosses into the other domain as a Gray code through a two-flop synchroniser, and the full and empty conditions are computed from these synchronised pointers.

Four choices are captured while the master reset `mrst` is high:
- the read mode, which is either standard or first-word-fall-through;
- the flag timing, which is either synchronous or asynchronous;
- the almost-empty offset `n`;
- the almost-full offset `m`.

In first-word-fall-through mode, the read data register works as one extra storage stage. The head word appears on `rdata` without a read request, and the capacity grows by one word.

Two active-low level flags warn of a nearly drained or nearly filled queue. In synchronous flag mode, each flag is a register in its own clock domain and is released through the synchroniser path. In asynchronous flag mode, each flag is derived directly from the raw write and read pointers. It is therefore set right after an edge in one domain and cleared right after an edge in the other. The storage is an inferred two-port RAM with a registered read port. Its depth is `2**ADDR_W`. Offsets must not exceed that depth.

Top module: `dcf_fifo`

## Requirements
- R1: In standard mode, a read request (`ren` high) at a read-clock edge while `rd_empty` is low puts the oldest stored word on `rdata` just after that edge. `rdata` holds its value on every other edge. Words leave in the order they were written.
- R2: In fall-through mode, the oldest word is shown on `rdata` with `rd_empty` low and no request needed. A request at a read-clock edge drops that word and shows the next one. `rdata` holds while a word is shown and no request is made.
- R3: A write while `wr_full` is high and a read while `rd_empty` is high are ignored. No pointer moves, and no word is lost or duplicated.
- R4: Capacity is `2**ADDR_W` words in standard mode and `2**ADDR_W + 1` words in fall-through mode. `wr_full` is high when the RAM holds `2**ADDR_W` words.
- R5: In standard mode, once the pointers are settled, `pae_n` is low when the FIFO holds `n` words or fewer and high otherwise.
- R6: In fall-through mode, once settled, `pae_n` is low when the FIFO (RAM plus output register) holds `n+1` words or fewer and high otherwise.
- R7: `paf_n` is low when the RAM holds `2**ADDR_W - m` words or more, which is `2**ADDR_W + 1 - m` words in total in fall-through mode with a word shown. It falls just after the write edge that reaches that level, in both flag modes.
- R8: `fwft_sel` (1 = fall-through), `sync_flag_sel` (1 = synchronous flags), `ae_off` and `af_off` are captured only while `mrst` is high. Later changes have no effect. After reset: `rd_empty`=1, `wr_full`=0, `pae_n`=0, `paf_n`=1.
- R9: With synchronous flags, `pae_n` rises on the 3rd or 4th read-clock rising edge after the write edge that lifts the count past its threshold. `paf_n` is still low just after the read edge that drops the count below its threshold.
- R10: With asynchronous flags, `pae_n` is high just after the write edge that lifts the count past its threshold. `paf_n` is high just after the read edge that drops the count below its threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous in each domain |
| fwft_sel | input | 1 | Read mode captured in reset: 1 = fall-through |
| sync_flag_sel | input | 1 | Flag timing captured in reset: 1 = synchronous |
| ae_off | input | ADDR_W+1 | Almost-empty offset n, captured in reset |
| af_off | input | ADDR_W+1 | Almost-full offset m, captured in reset |
| wen | input | 1 | Write request |
| wdata | input | DATA_W | Write data |
| ren | input | 1 | Read request |
| rdata | output | DATA_W | Registered read data |
| wr_full | output | 1 | No room for a write |
| rd_empty | output | 1 | No word to read |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
Each of the four mode combinations is reset in turn. In each one, the FIFO is filled one word at a time to capacity and then drained one word at a time, with a settled flag check after every step. This pins down each flag threshold and the capacity, which differ by one word between the two read modes. Timed single writes and reads at the threshold crossings tell the two flag timings apart: an asynchronous flag changes just after the edge, while a synchronous one waits for the synchroniser. A write into a full FIFO and a read from an empty one are followed by draining, which shows whether a stray word slipped in or out. Finally, a burst of randomly spaced writes and reads on the unrelated clocks checks word order while both pointers move at once.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {RD_STANDARD = 1'b0, RD_FALLTHRU = 1'b1} rd_mode_e;
  typedef enum logic {FLAGS_ASYNC = 1'b0, FLAGS_SYNC = 1'b1} flag_mode_e;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, reset only on the output register
  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side import dcf_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              mrst,
  input  logic              sync_sel,
  input  logic [ADDR_W:0]   af_off,
  input  logic              wen,
  input  logic [ADDR_W:0]   rgray_s,
  input  logic [ADDR_W:0]   rptr_raw,
  output logic [ADDR_W:0]   wptr,
  output logic [ADDR_W:0]   wgray,
  output logic              wr_full,
  output logic              paf_n,
  output logic              ram_we,
  output logic [ADDR_W-1:0] waddr
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  flag_mode_e    mode_q;
  logic [PW-1:0] m_q;
  logic [PW-1:0] rptr_s;
  logic [PW-1:0] wcnt;
  logic [PW-1:0] wptr_nx;
  logic [PW-1:0] thr;
  logic [PW-1:0] raw_cnt;
  logic          paf_q;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    rptr_s  = gray2bin(rgray_s);
    wcnt    = wptr - rptr_s;
    wr_full = (wcnt == DEPTH_P);
    ram_we  = wen && !wr_full;
    wptr_nx = wptr + PW'(ram_we);
    thr     = DEPTH_P - m_q;
    raw_cnt = wptr - rptr_raw;
  end

  assign waddr = wptr[ADDR_W-1:0];
  // asynchronous timing: level from the live pointers of both domains
  assign paf_n = (mode_q == FLAGS_SYNC) ? paf_q : !(raw_cnt >= thr);

  always_ff @(posedge wclk) begin
    if (mrst) begin
      wptr   <= '0;
      wgray  <= '0;
      paf_q  <= 1'b1;
      m_q    <= af_off;
      mode_q <= sync_sel ? FLAGS_SYNC : FLAGS_ASYNC;
    end else begin
      wptr  <= wptr_nx;
      wgray <= wptr_nx ^ (wptr_nx >> 1);
      paf_q <= !((wptr_nx - rptr_s) >= thr);
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side import dcf_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              rclk,
  input  logic              mrst,
  input  logic              fwft_sel,
  input  logic              sync_sel,
  input  logic [ADDR_W:0]   ae_off,
  input  logic              ren,
  input  logic [ADDR_W:0]   wgray_s,
  input  logic [ADDR_W:0]   wptr_raw,
  output logic [ADDR_W:0]   rptr,
  output logic [ADDR_W:0]   rgray,
  output logic              rd_empty,
  output logic              pae_n,
  output logic              ram_re,
  output logic [ADDR_W-1:0] raddr,
  output logic              fwft_on
);
  localparam int PW = ADDR_W + 1;
  localparam int CW = PW + 1;

  rd_mode_e      rmode_q;
  flag_mode_e    fmode_q;
  logic [PW-1:0] n_q;
  logic [PW-1:0] wptr_s;
  logic [PW-1:0] rcnt;
  logic [PW-1:0] rptr_nx;
  logic          ovalid;
  logic          ovalid_nx;
  logic          pae_q;
  logic [CW-1:0] thr;
  logic [CW-1:0] tot_nx;
  logic [CW-1:0] raw_tot;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    fwft_on = (rmode_q == RD_FALLTHRU);
    wptr_s  = gray2bin(wgray_s);
    rcnt    = wptr_s - rptr;
    if (fwft_on) begin
      // refill the output register whenever it is free or being consumed
      ram_re    = (rcnt != '0) && (!ovalid || ren);
      ovalid_nx = ram_re ? 1'b1 : (ren ? 1'b0 : ovalid);
    end else begin
      ram_re    = ren && (rcnt != '0);
      ovalid_nx = 1'b0;
    end
    rd_empty = fwft_on ? !ovalid : (rcnt == '0);
    rptr_nx  = rptr + PW'(ram_re);
    thr      = CW'(n_q) + CW'(fwft_on);
    tot_nx   = CW'(wptr_s - rptr_nx) + CW'(ovalid_nx);
    raw_tot  = CW'(wptr_raw - rptr) + CW'(ovalid);
  end

  assign raddr = rptr[ADDR_W-1:0];
  assign pae_n = (fmode_q == FLAGS_SYNC) ? pae_q : (raw_tot > thr);

  always_ff @(posedge rclk) begin
    if (mrst) begin
      rptr    <= '0;
      rgray   <= '0;
      ovalid  <= 1'b0;
      pae_q   <= 1'b0;
      n_q     <= ae_off;
      rmode_q <= fwft_sel ? RD_FALLTHRU : RD_STANDARD;
      fmode_q <= sync_sel ? FLAGS_SYNC : FLAGS_ASYNC;
    end else begin
      rptr   <= rptr_nx;
      rgray  <= rptr_nx ^ (rptr_nx >> 1);
      ovalid <= ovalid_nx;
      pae_q  <= (tot_nx > thr);
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst,
  input  logic              fwft_sel,
  input  logic              sync_flag_sel,
  input  logic [ADDR_W:0]   ae_off,
  input  logic [ADDR_W:0]   af_off,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_full,
  output logic              rd_empty,
  output logic              pae_n,
  output logic              paf_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wptr_w, wgray_w, rptr_r, rgray_r;
  logic [PW-1:0]     wgray_at_r, rgray_at_w;
  logic              ram_we, ram_re, fwft_on;
  logic [ADDR_W-1:0] waddr, raddr;

  dcf_sync2 #(.W(PW)) u_w2r (
    .clk(rclk), .rst(mrst), .d(wgray_w), .q(wgray_at_r)
  );

  dcf_sync2 #(.W(PW)) u_r2w (
    .clk(wclk), .rst(mrst), .d(rgray_r), .q(rgray_at_w)
  );

  dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wclk(wclk), .mrst(mrst), .sync_sel(sync_flag_sel), .af_off(af_off),
    .wen(wen), .rgray_s(rgray_at_w), .rptr_raw(rptr_r),
    .wptr(wptr_w), .wgray(wgray_w), .wr_full(wr_full), .paf_n(paf_n),
    .ram_we(ram_we), .waddr(waddr)
  );

  dcf_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .rclk(rclk), .mrst(mrst), .fwft_sel(fwft_sel), .sync_sel(sync_flag_sel),
    .ae_off(ae_off), .ren(ren), .wgray_s(wgray_at_r), .wptr_raw(wptr_w),
    .rptr(rptr_r), .rgray(rgray_r), .rd_empty(rd_empty), .pae_n(pae_n),
    .ram_re(ram_re), .raddr(raddr), .fwft_on(fwft_on)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk(wclk), .we(ram_we), .waddr(waddr), .wdata(wdata),
    .rclk(rclk), .rrst(mrst), .re(ram_re), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              wclk,
  input logic              rclk,
  input logic              mrst,
  input logic              wen,
  input logic              ren,
  input logic              wr_full,
  input logic              rd_empty,
  input logic [DATA_W-1:0] rdata,
  input logic [ADDR_W:0]   wptr,
  input logic [ADDR_W:0]   rptr,
  input logic [ADDR_W:0]   wgray,
  input logic [ADDR_W:0]   rgray,
  input logic              fwft_on
);
  // R3: a write refused for lack of room leaves the write pointer alone
  a_r3_no_write_when_full: assert property (@(posedge wclk) disable iff (mrst)
    (wen && wr_full) |=> $stable(wptr));

  // R3: a standard-mode read on empty leaves the read pointer alone
  a_r3_no_read_when_empty: assert property (@(posedge rclk) disable iff (mrst)
    (!fwft_on && ren && rd_empty) |=> $stable(rptr));

  // R1: standard-mode output changes only on an accepted read
  a_r1_std_hold: assert property (@(posedge rclk) disable iff (mrst)
    (!fwft_on && !(ren && !rd_empty)) |=> $stable(rdata));

  // R2: a shown fall-through word stays until it is requested
  a_r2_fwft_hold: assert property (@(posedge rclk) disable iff (mrst)
    (fwft_on && !rd_empty && !ren) |=> $stable(rdata));

  // R9: crossing pointers change by at most one bit per edge
  a_r9_wgray_step: assert property (@(posedge wclk) disable iff (mrst)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r9_rgray_step: assert property (@(posedge rclk) disable iff (mrst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind dcf_fifo dcf_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .wen(wen), .ren(ren),
  .wr_full(wr_full), .rd_empty(rd_empty), .rdata(rdata),
  .wptr(wptr_w), .rptr(rptr_r), .wgray(wgray_w), .rgray(rgray_r),
  .fwft_on(fwft_on)
);

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int NOFF = 3;
  localparam int MOFF = 2;

  logic wclk = 1'b0, rclk = 1'b0, mrst = 1'b1;
  logic fwft_sel = 1'b0, sync_sel = 1'b0, wen = 1'b0, ren = 1'b0;
  logic [PW-1:0] ae_off = '0, af_off = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic wr_full, rd_empty, pae_n, paf_n;

  int checks = 0, fails = 0;
  int q[$];
  bit cf, cs;

  always #10 wclk = ~wclk;          // 50 MHz write clock
  initial begin
    #3;
    forever #13 rclk = ~rclk;       // unrelated read clock
  end

  dcf_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .fwft_sel(fwft_sel),
    .sync_flag_sel(sync_sel), .ae_off(ae_off), .af_off(af_off),
    .wen(wen), .wdata(wdata), .ren(ren), .rdata(rdata),
    .wr_full(wr_full), .rd_empty(rd_empty), .pae_n(pae_n), .paf_n(paf_n)
  );

  task automatic chk_ok(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (fwft=%0d sync=%0d)", req, act, exp, cf, cs);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    chk_ok(req, act == exp, act, exp);
  endtask

  function automatic int cap();
    return cf ? DEPTH + 1 : DEPTH;
  endfunction

  task automatic settle();
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    #1;
  endtask

  // model accepts a word only while below capacity (used in settled phases)
  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1'b1;
    wdata = d;
    @(posedge wclk);
    if (q.size() < cap()) q.push_back(int'(d));
    #1 wen = 1'b0;
  endtask

  // probe >= 0: expected paf_n just after the read edge
  task automatic rd(input string tag, input int probe);
    logic [DW-1:0] pre, got;
    int exp;
    @(negedge rclk);
    pre = rdata;
    ren = 1'b1;
    @(posedge rclk);
    #1 ren = 1'b0;
    got = cf ? pre : rdata;
    if (probe >= 0) chk(cs ? "R9 paf_n after read edge" : "R10 paf_n after read edge", int'(paf_n), probe);
    if (q.size() > 0) begin
      exp = q.pop_front();
      chk(tag, int'(got), exp);
    end
  endtask

  task automatic check_flags();
    int tot, ram, th;
    tot = q.size();
    ram = (cf && tot > 0) ? tot - 1 : tot;
    th  = cf ? NOFF + 1 : NOFF;
    chk(cf ? "R6 pae_n" : "R5 pae_n", int'(pae_n), (tot > th) ? 1 : 0);
    chk("R7 paf_n", int'(paf_n), (ram >= DEPTH - MOFF) ? 0 : 1);
    chk("R4 wr_full", int'(wr_full), (ram == DEPTH) ? 1 : 0);
    chk(cf ? "R2 rd_empty" : "R1 rd_empty", int'(rd_empty), (tot == 0) ? 1 : 0);
  endtask

  task automatic do_reset(input bit f, input bit s);
    cf = f;
    cs = s;
    q.delete();
    wen = 1'b0;
    ren = 1'b0;
    fwft_sel = f;
    sync_sel = s;
    ae_off = PW'(NOFF);
    af_off = PW'(MOFF);
    mrst = 1'b1;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge wclk);
    mrst = 1'b0;
    // R8: pins changed after reset must be ignored
    fwft_sel = ~f;
    sync_sel = ~s;
    ae_off = PW'(9);
    af_off = PW'(11);
    settle();
    chk("R8 rd_empty after reset", int'(rd_empty), 1);
    chk("R8 wr_full after reset", int'(wr_full), 0);
    chk("R8 pae_n after reset", int'(pae_n), 0);
    chk("R8 paf_n after reset", int'(paf_n), 1);
  endtask

  task automatic stream(input int seed);
    int total = 40;
    fork
      begin : writer
        int sent = 0;
        while (sent < total) begin
          @(negedge wclk);
          if (($urandom % 2) == 0 && !wr_full) begin
            wen = 1'b1;
            wdata = DW'(seed + sent * 7);
            q.push_back(int'(wdata));
            sent++;
          end
          @(posedge wclk);
          #1 wen = 1'b0;
        end
      end
      begin : reader
        int got_n = 0;
        logic [DW-1:0] pre, got;
        int exp;
        while (got_n < total) begin
          @(negedge rclk);
          if (!rd_empty && ($urandom % 3) != 0) begin
            pre = rdata;
            ren = 1'b1;
            @(posedge rclk);
            #1 ren = 1'b0;
            got = cf ? pre : rdata;
            exp = q.pop_front();
            chk(cf ? "R2 stream order" : "R1 stream order", int'(got), exp);
            got_n++;
          end
        end
      end
    join
  endtask

  task automatic run_cfg(input bit f, input bit s);
    int th, edges, tot0;
    do_reset(f, s);
    th = f ? NOFF + 1 : NOFF;

    // almost-empty release timing
    for (int i = 0; i < th; i++) wr(DW'(8'h10 + i));
    settle();
    check_flags();
    @(negedge wclk);
    wen = 1'b1;
    wdata = 8'h3C;
    @(posedge wclk);
    q.push_back(8'h3C);
    #1 wen = 1'b0;
    if (s) begin
      edges = 0;
      while (edges < 8) begin
        @(posedge rclk);
        edges++;
        @(negedge rclk);
        if (pae_n) break;
      end
      chk_ok("R9 pae_n release edges", (edges == 3 || edges == 4), edges, 3);
    end else begin
      chk("R10 pae_n just after write edge", int'(pae_n), 1);
    end
    settle();
    check_flags();

    // almost-full set and release timing
    tot0 = DEPTH - MOFF - 1 + (f ? 1 : 0);
    while (q.size() < tot0) wr(DW'(8'h40 + q.size()));
    settle();
    check_flags();
    wr(8'h5A);
    chk("R7 paf_n just after write edge", int'(paf_n), 0);
    settle();
    check_flags();
    rd(f ? "R2 data" : "R1 data", s ? 0 : 1);
    settle();
    check_flags();

    // fill to capacity, then a refused write (R3, R4)
    while (q.size() < cap()) wr(DW'(8'h80 + q.size()));
    settle();
    check_flags();
    chk(f ? "R4 fwft capacity" : "R4 std capacity", q.size(), cap());
    wr(8'hEE);
    settle();
    check_flags();
    chk("R3 full after refused write", int'(wr_full), 1);

    // drain one word at a time; a leaked 8'hEE would surface here
    while (q.size() > 0) begin
      rd(f ? "R2 drain" : "R1 drain", -1);
      settle();
      check_flags();
    end

    // read on empty must not move the read side (R3)
    @(negedge rclk);
    ren = 1'b1;
    @(posedge rclk);
    #1 ren = 1'b0;
    settle();
    chk("R3 empty after refused read", int'(rd_empty), 1);
    wr(8'h55);
    settle();
    rd("R3 word after refused read", -1);
    settle();
    check_flags();

    stream(100 + 3 * int'(f) + 5 * int'(s));
    settle();
    check_flags();
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    checks++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b0, 1'b1);
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule